// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs from a slow tick enable, separate from the bus activity that configures it. A power-of-two prescaler divides the tick. A 12-bit down-counter counts the divided ticks. When the counter steps past zero, the block sends a one-cycle reset request to the system and reloads itself. Software reaches four registers through a single-cycle write port with a combinational read path.

The configuration registers are protected by a key. Writing one value to the key register opens the prescaler and reload registers for writing, and another value closes them again. A third value starts the watchdog. A fourth value refreshes the countdown. Once started, the watchdog runs until system reset.

Prescaler and reload writes go into holding copies first. They take effect only after a fixed number of ticks. While a copy is waiting, its pending flag is set in the status register.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `rst_req_o` is 0, the prescaler reads 0 (divide by 4), the reload reads 0xFFF and the status reads 0. A start without any configuration expires after 4096*4 ticks.
- R2: A key write of 0x5555 opens configuration access and a key write of 0x0000 closes it. Any other key value leaves access as it was.
- R3: Prescaler and reload writes made while access is closed are dropped: the readback does not change and no pending flag is set.
- R4: Prescaler code c divides the tick by 4<<c. A written value above the largest code, log2(MAX_DIV)-2, is stored as that largest code.
- R5: The reload register keeps only the low 12 bits of a write.
- R6: Status bit 0 flags a pending prescaler update and status bit 1 flags a pending reload update. An accepted write sets its flag. The flag clears BUSY_TICKS ticks later, and the new value is in use from then on. While no ticks arrive, the flag stays set.
- R7: A key write of 0xCCCC starts the watchdog. With tick_i high every cycle, `rst_req_o` first rises (reload+1)*(4<<code) cycles after the start write.
- R8: A key write of 0xAAAA reloads the counter and clears the prescaler phase. The next expiry then comes one full period after the refresh.
- R9: `rst_req_o` is high for exactly one cycle. Counting then continues from the reload value, so the next request follows one full period later.
- R10: After a start, no key write stops the watchdog, including 0x0000.
- R11: Register map: address 0 is the key register (reads 0), 1 the prescaler code, 2 the reload value, 3 the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow watchdog tick enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest situation to reach from the ports is an expiry with an exact cycle count. No key write stops the watchdog once it runs, so every configuration needs a fresh system reset. The bench sweeps every prescaler code against several reload values. For each one it applies reset, configures, waits for the pending flags to clear, starts, and counts cycles to the first request. Refresh and stop attempts are interleaved with the counting, and the cycle offsets they use up are accounted for in the expected value.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [15:0] KEY_UNLOCK = 16'h5555;
  localparam logic [15:0] KEY_LOCK   = 16'h0000;
  localparam logic [15:0] KEY_START  = 16'hCCCC;
  localparam logic [15:0] KEY_FEED   = 16'hAAAA;

  typedef enum logic [1:0] {
    A_KEY  = 2'd0,
    A_PRE  = 2'd1,
    A_RLD  = 2'd2,
    A_STAT = 2'd3
  } addr_e;
endpackage

// File: rtl/kwd_keys.sv
module kwd_keys
  import kwd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_key_i,
  input  logic [DW-1:0] wdata_i,
  output logic          unlock_o,
  output logic          running_o,
  output logic          restart_o
);
  logic start_hit, feed_hit;

  assign start_hit = wr_key_i && (wdata_i == DW'(KEY_START));
  assign feed_hit  = wr_key_i && (wdata_i == DW'(KEY_FEED));
  assign restart_o = start_hit || feed_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_o  <= 1'b0;
      running_o <= 1'b0;
    end else begin
      if (wr_key_i && wdata_i == DW'(KEY_UNLOCK))    unlock_o <= 1'b1;
      else if (wr_key_i && wdata_i == DW'(KEY_LOCK)) unlock_o <= 1'b0;
      if (start_hit) running_o <= 1'b1;
    end
  end
endmodule

// File: rtl/kwd_shadow.sv
module kwd_shadow #(
  parameter int             W          = 12,
  parameter int             BUSY_TICKS = 3,
  parameter logic [W-1:0]   RST_VAL    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         busy_o
);
  localparam int BW = $clog2(BUSY_TICKS + 1);

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= RST_VAL;
      active_o <= RST_VAL;
      bcnt     <= '0;
    end else if (load_i) begin
      shadow_o <= data_i;
      bcnt     <= BW'(BUSY_TICKS);
    end else if (tick_i && bcnt != '0) begin
      bcnt <= bcnt - 1'b1;
      if (bcnt == BW'(1)) active_o <= shadow_o;
    end
  end

  assign busy_o = (bcnt != '0);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int RLD_W   = 12,
  parameter int MAX_DIV = 256,
  parameter int PR_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             running_i,
  input  logic             restart_i,
  input  logic [PR_W-1:0]  code_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic             expire_o
);
  localparam int PCW = $clog2(MAX_DIV);

  logic [PCW-1:0]   pcnt, plim;
  logic [RLD_W-1:0] cnt;

  assign plim = PCW'((4 << code_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt     <= '0;
      cnt      <= '1;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (restart_i) begin
        pcnt <= '0;
        cnt  <= reload_i;
      end else if (running_i && tick_i) begin
        // >= keeps a lowered prescaler from running the phase past its limit
        if (pcnt >= plim) begin
          pcnt <= '0;
          if (cnt == '0) begin
            expire_o <= 1'b1;
            cnt      <= reload_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int MAX_DIV    = 256,
  parameter int RLD_W      = 12,
  parameter int BUSY_TICKS = 3,
  parameter int DW         = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rst_req_o
);
  localparam int MAX_CODE = $clog2(MAX_DIV) - 2;
  localparam int PR_W     = $clog2(MAX_CODE + 1);

  logic             unlock, running, restart;
  logic             wr_key, wr_pre, wr_rld;
  logic [PR_W-1:0]  code_in, pre_shadow, pre_active;
  logic [RLD_W-1:0] rld_shadow, rld_active;
  logic             pre_busy, rld_busy;

  assign wr_key = wr_i && addr_e'(addr_i) == A_KEY;
  assign wr_pre = wr_i && addr_e'(addr_i) == A_PRE && unlock;
  assign wr_rld = wr_i && addr_e'(addr_i) == A_RLD && unlock;

  // over-range prescaler codes saturate to the largest ratio
  assign code_in = (wdata_i > DW'(MAX_CODE)) ? PR_W'(MAX_CODE) : wdata_i[PR_W-1:0];

  kwd_keys #(.DW(DW)) u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_key_i  (wr_key),
    .wdata_i   (wdata_i),
    .unlock_o  (unlock),
    .running_o (running),
    .restart_o (restart)
  );

  kwd_shadow #(.W(PR_W), .BUSY_TICKS(BUSY_TICKS), .RST_VAL('0)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .load_i   (wr_pre),
    .data_i   (code_in),
    .shadow_o (pre_shadow),
    .active_o (pre_active),
    .busy_o   (pre_busy)
  );

  kwd_shadow #(.W(RLD_W), .BUSY_TICKS(BUSY_TICKS), .RST_VAL('1)) u_rld (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .load_i   (wr_rld),
    .data_i   (wdata_i[RLD_W-1:0]),
    .shadow_o (rld_shadow),
    .active_o (rld_active),
    .busy_o   (rld_busy)
  );

  kwd_counter #(.RLD_W(RLD_W), .MAX_DIV(MAX_DIV), .PR_W(PR_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .running_i (running),
    .restart_i (restart),
    .code_i    (pre_active),
    .reload_i  (rld_active),
    .expire_o  (rst_req_o)
  );

  always_comb begin
    unique case (addr_e'(addr_i))
      A_PRE:   rdata_o = DW'(pre_shadow);
      A_RLD:   rdata_o = DW'(rld_shadow);
      A_STAT:  rdata_o = DW'({rld_busy, pre_busy});
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
  parameter int PR_W  = 3,
  parameter int RLD_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [1:0]       addr_i,
  input logic             rst_req_o,
  input logic             unlock,
  input logic             running,
  input logic             pre_busy,
  input logic [PR_W-1:0]  pre_shadow,
  input logic [RLD_W-1:0] rld_shadow
);
  assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_req_needs_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> running);

  assert_run_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |=> running);

  assert_locked_pre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd1 && !unlock) |=> $stable(pre_shadow));

  assert_locked_rld_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd2 && !unlock) |=> $stable(rld_shadow));

  assert_busy_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_busy) |-> $past(wr_i && addr_i == 2'd1 && unlock));
endmodule

bind keyed_wdog kwd_chk #(.PR_W(PR_W), .RLD_W(RLD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .rst_req_o  (rst_req_o),
  .unlock     (unlock),
  .running    (running),
  .pre_busy   (pre_busy),
  .pre_shadow (pre_shadow),
  .rld_shadow (rld_shadow)
);

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_DIV    = 256;
  localparam int BUSY       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog #(.MAX_DIV(MAX_DIV), .RLD_W(12), .BUSY_TICKS(BUSY), .DW(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr = 1'b0; tick = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input int code, input int rld);
    wr_reg(2'd0, 16'h5555);
    wr_reg(2'd1, 16'(code));
    wr_reg(2'd2, 16'(rld));
    idle(BUSY + 1);
  endtask

  // counts negedges after the start edge; off = edges already used up
  task automatic measure(input int off, input int exp, input string req);
    int n = off;
    bit seen = 0;
    while (!seen && n < exp + 50) begin
      @(negedge clk); n++;
      if (rst_req) seen = 1;
    end
    chk(req, n, exp);
    @(negedge clk);
    chk("R9 width", int'(rst_req), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    // R1 reset state and R11 key readback
    do_reset();
    chk("R1 req", int'(rst_req), 0);
    rd_reg(2'd1, v); chk("R1 presc", v, 0);
    rd_reg(2'd2, v); chk("R1 reload", v, 12'hFFF);
    rd_reg(2'd3, v); chk("R1 status", v, 0);
    rd_reg(2'd0, v); chk("R11 key reads 0", v, 0);
    wr_reg(2'd0, 16'hCCCC);
    measure(0, 4096 * 4, "R1 default period");

    // R3 locked writes dropped, R2 lock/unlock
    do_reset();
    wr_reg(2'd1, 16'd3);
    rd_reg(2'd1, v); chk("R3 presc locked", v, 0);
    rd_reg(2'd3, v); chk("R3 no busy", v, 0);
    wr_reg(2'd0, 16'h5555);
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd2, 16'd5);
    rd_reg(2'd2, v); chk("R2 relocked", v, 12'hFFF);
    wr_reg(2'd0, 16'h5555);
    wr_reg(2'd0, 16'h1234);
    wr_reg(2'd2, 16'd5);
    rd_reg(2'd2, v); chk("R2 other key keeps access", v, 5);

    // R4 clamp, R5 mask
    wr_reg(2'd1, 16'd7);
    rd_reg(2'd1, v); chk("R4 clamp 7", v, 6);
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, v); chk("R4 clamp FFFF", v, 6);
    wr_reg(2'd2, 16'hF123);
    rd_reg(2'd2, v); chk("R5 mask", v, 12'h123);

    // R6 pending flags
    do_reset();
    wr_reg(2'd0, 16'h5555);
    wr_reg(2'd1, 16'd2);
    rd_reg(2'd3, v); chk("R6 presc busy", v, 1);
    idle(BUSY - 1);
    rd_reg(2'd3, v); chk("R6 presc still busy", v, 1);
    idle(1);
    rd_reg(2'd3, v); chk("R6 presc done", v, 0);
    wr_reg(2'd2, 16'd7);
    rd_reg(2'd3, v); chk("R6 reload busy", v, 2);
    tick = 1'b0;
    idle(10);
    rd_reg(2'd3, v); chk("R6 held without ticks", v, 2);
    tick = 1'b1;
    idle(BUSY);
    rd_reg(2'd3, v); chk("R6 reload done", v, 0);
    wr_reg(2'd0, 16'hCCCC);
    measure(0, 8 * 16, "R6 new values in use");

    // R4/R7 sweep over codes and reloads
    for (int c = 0; c <= 6; c++) begin
      for (int r = 0; r <= 3; r += 3) begin
        do_reset();
        configure(c, r);
        wr_reg(2'd0, 16'hCCCC);
        measure(0, (r + 1) * (4 << c), "R4 R7 sweep");
      end
    end

    // R9 repeating period
    do_reset();
    configure(0, 2);
    wr_reg(2'd0, 16'hCCCC);
    measure(0, 12, "R7 first");
    measure(1, 12, "R9 second");

    // R10 cannot be stopped
    do_reset();
    configure(1, 1);
    wr_reg(2'd0, 16'hCCCC);
    wr_reg(2'd0, 16'h0000);
    wr_reg(2'd0, 16'h5555);
    wr_reg(2'd0, 16'h1234);
    measure(3, 16, "R10");

    // R8 refresh
    do_reset();
    configure(0, 1);
    wr_reg(2'd0, 16'hCCCC);
    v = 0;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 5; j++) begin
        @(negedge clk);
        if (rst_req) v = 1;
      end
      wr_reg(2'd0, 16'hAAAA);
    end
    chk("R8 no expiry while refreshed", v, 0);
    measure(0, 8, "R8 period after refresh");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule